// File: doc/BRIEF.md
# Datapath Function Unit with Status Flags

This block is the combinational operation stage of a small register-based datapath. It takes two n-bit operands, A and B, and produces a single result F. A 4-bit function code selects the operation: an add/subtract/increment/decrement family, four bitwise operations, a pass of B, or a one-position shift of B. The block also drives four status flags: overflow, carry, negative and zero.

The function code is split inside the block. Its two upper bits choose between the arithmetic, logic and shift sections. Its lower bits drive the adder's operand-B conditioning and its carry-in. The same lower bits select the bitwise operation and the shift direction. A surrounding controller places operands on the two buses and sets the code. It then captures F and the flags in its own registers on the next clock edge. The shifter takes a serial fill bit for each direction, and it reports the bit each shift direction pushes out.

Top module: `datapath_fu`

## Requirements
- R1: For codes with bit 3 = 0, F = A + Y + cin modulo 2^n. cin is code bit 0. Code bits [2:1] pick Y: 00 gives zero, 01 gives B, 10 gives ~B, 11 gives all ones. So 0000=A, 0001=A+1, 0010=A+B, 0011=A+B+1, 0100=A+~B, 0101=A-B, 0110=A-1, 0111=A.
- R2: For codes with bit 3 = 0, C equals the carry out of the n-bit addition A + Y + cin.
- R3: For codes with bit 3 = 0, V is 1 exactly when the MSBs of A and Y are equal and the MSB of F differs from them.
- R4: Codes 1000, 1001, 1010 and 1011 give F = A AND B, A OR B, A XOR B and NOT A respectively.
- R5: Codes 1100 and 1111 give F = B.
- R6: Code 1101 gives F = B shifted right by one position. The vacated MSB takes fill_r_i.
- R7: Code 1110 gives F = B shifted left by one position. The vacated LSB takes fill_l_i.
- R8: For every code with bit 3 = 1, C and V are 0.
- R9: N always equals the MSB of F. Z is 1 exactly when F is all zeros.
- R10: sout_r_o always equals B[0], which is the bit a right shift pushes out. sout_l_o always equals B[n-1], which is the bit a left shift pushes out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| fsel_i | input | 4 | Function code |
| fill_r_i | input | 1 | Fill bit for the MSB on a right shift |
| fill_l_i | input | 1 | Fill bit for the LSB on a left shift |
| f_o | output | WIDTH | Result |
| v_o | output | 1 | Signed overflow |
| c_o | output | 1 | Carry out |
| n_o | output | 1 | Negative (MSB of result) |
| z_o | output | 1 | Zero result |
| sout_r_o | output | 1 | Bit pushed out by a right shift |
| sout_l_o | output | 1 | Bit pushed out by a left shift |

## Verification
The overflow flag is the hardest behaviour to reach, because it needs operands whose signs line up with the sign of the conditioned B operand. For the decrement code and the A+~B codes, the second operand is the complement of B or all ones. Random operands rarely land on the boundaries between the most negative and most positive values. Directed vectors therefore apply the signed extremes with each arithmetic code, along with zero minus one and all-ones plus one. A long random run over every code and both fill bits then covers the rest of the space.

// File: rtl/fu_pkg.sv
package fu_pkg;

    typedef enum logic [1:0] {
        LOP_AND = 2'b00,
        LOP_OR  = 2'b01,
        LOP_XOR = 2'b10,
        LOP_NOT = 2'b11
    } lop_e;

    typedef enum logic [1:0] {
        SH_PASS  = 2'b00,
        SH_RIGHT = 2'b01,
        SH_LEFT  = 2'b10,
        SH_SPARE = 2'b11
    } shop_e;

    typedef enum logic [1:0] {
        SEC_ARITH,
        SEC_LOGIC,
        SEC_SHIFT
    } section_e;

    typedef struct packed {
        logic v;
        logic c;
        logic n;
        logic z;
    } flags_t;

    function automatic section_e decode_section(input logic [3:0] code);
        if (code[3] && code[2])
            return SEC_SHIFT;
        else if (code[3])
            return SEC_LOGIC;
        else
            return SEC_ARITH;
    endfunction

    function automatic logic signed_ovf(input logic msb_x, input logic msb_y,
                                        input logic msb_s);
        return (msb_x == msb_y) && (msb_s != msb_x);
    endfunction

endpackage

// File: rtl/fu_arith.sv
module fu_arith #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       ysel_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);
    import fu_pkg::*;

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] y_w;
    logic [WIDTH:0]   full_w;

    always_comb begin
        unique case (ysel_i)
            2'b00:   y_w = '0;
            2'b01:   y_w = b_i;
            2'b10:   y_w = ~b_i;
            default: y_w = '1;
        endcase
    end

    assign full_w = {1'b0, x_i} + {1'b0, y_w} + {{WIDTH{1'b0}}, cin_i};
    assign sum_o  = full_w[MSB:0];
    assign cout_o = full_w[WIDTH];
    assign ovf_o  = signed_ovf(x_i[MSB], y_w[MSB], full_w[MSB]);

endmodule

// File: rtl/fu_logic.sv
module fu_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] res_o
);
    import fu_pkg::*;

    lop_e op_w;
    assign op_w = lop_e'(op_i);

    always_comb begin
        unique case (op_w)
            LOP_AND: res_o = x_i & b_i;
            LOP_OR:  res_o = x_i | b_i;
            LOP_XOR: res_o = x_i ^ b_i;
            default: res_o = ~x_i;
        endcase
    end

endmodule

// File: rtl/fu_shift.sv
module fu_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       op_i,
    input  logic             fill_r_i,
    input  logic             fill_l_i,
    output logic [WIDTH-1:0] res_o,
    output logic             sout_r_o,
    output logic             sout_l_o
);
    import fu_pkg::*;

    localparam int MSB = WIDTH - 1;

    shop_e op_w;
    assign op_w = shop_e'(op_i);

    always_comb begin
        unique case (op_w)
            SH_RIGHT: res_o = {fill_r_i, b_i[MSB:1]};
            SH_LEFT:  res_o = {b_i[MSB-1:0], fill_l_i};
            default:  res_o = b_i;
        endcase
    end

    assign sout_r_o = b_i[0];
    assign sout_l_o = b_i[MSB];

endmodule

// File: rtl/datapath_fu.sv
module datapath_fu #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       fsel_i,
    input  logic             fill_r_i,
    input  logic             fill_l_i,
    output logic [WIDTH-1:0] f_o,
    output logic             v_o,
    output logic             c_o,
    output logic             n_o,
    output logic             z_o,
    output logic             sout_r_o,
    output logic             sout_l_o
);
    import fu_pkg::*;

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] arith_w, logic_w, shift_w;
    logic             cout_w, ovf_w;
    section_e         sec_w;
    flags_t           flags_w;

    fu_arith #(.WIDTH(WIDTH)) i_arith (
        .x_i    (a_i),
        .b_i    (b_i),
        .ysel_i (fsel_i[2:1]),
        .cin_i  (fsel_i[0]),
        .sum_o  (arith_w),
        .cout_o (cout_w),
        .ovf_o  (ovf_w)
    );

    fu_logic #(.WIDTH(WIDTH)) i_logic (
        .x_i   (a_i),
        .b_i   (b_i),
        .op_i  (fsel_i[1:0]),
        .res_o (logic_w)
    );

    fu_shift #(.WIDTH(WIDTH)) i_shift (
        .b_i      (b_i),
        .op_i     (fsel_i[1:0]),
        .fill_r_i (fill_r_i),
        .fill_l_i (fill_l_i),
        .res_o    (shift_w),
        .sout_r_o (sout_r_o),
        .sout_l_o (sout_l_o)
    );

    assign sec_w = decode_section(fsel_i);

    always_comb begin
        unique case (sec_w)
            SEC_SHIFT: f_o = shift_w;
            SEC_LOGIC: f_o = logic_w;
            default:   f_o = arith_w;
        endcase
    end

    always_comb begin
        flags_w.c = (sec_w == SEC_ARITH) ? cout_w : 1'b0;
        flags_w.v = (sec_w == SEC_ARITH) ? ovf_w  : 1'b0;
        flags_w.n = f_o[MSB];
        flags_w.z = (f_o == '0);
    end

    assign v_o = flags_w.v;
    assign c_o = flags_w.c;
    assign n_o = flags_w.n;
    assign z_o = flags_w.z;

endmodule

// File: rtl/fu_checker.sv
module fu_checker #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [3:0]       fsel_i,
    input logic             fill_r_i,
    input logic             fill_l_i,
    input logic [WIDTH-1:0] f_o,
    input logic             v_o,
    input logic             c_o,
    input logic             n_o,
    input logic             z_o,
    input logic             sout_r_o,
    input logic             sout_l_o
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        if (fsel_i[3]) begin
            p_no_flags_r8: assert (!c_o && !v_o);
        end
        p_zero_flag_r9: assert (z_o == (f_o == '0));
        p_neg_flag_r9:  assert (n_o == f_o[MSB]);
        if (fsel_i == 4'b1100 || fsel_i == 4'b1111) begin
            p_pass_b_r5: assert (f_o == b_i);
        end
        if (fsel_i == 4'b1101) begin
            p_shift_right_r6: assert (f_o == {fill_r_i, b_i[MSB:1]});
        end
        if (fsel_i == 4'b1110) begin
            p_shift_left_r7: assert (f_o == {b_i[MSB-1:0], fill_l_i});
        end
        if (fsel_i == 4'b1000) begin
            p_and_r4: assert (f_o == (a_i & b_i));
        end
        p_serial_out_r10: assert (sout_r_o == b_i[0] && sout_l_o == b_i[MSB]);
    end

endmodule

bind datapath_fu fu_checker #(.WIDTH(WIDTH)) i_fu_checker (
    .a_i      (a_i),
    .b_i      (b_i),
    .fsel_i   (fsel_i),
    .fill_r_i (fill_r_i),
    .fill_l_i (fill_l_i),
    .f_o      (f_o),
    .v_o      (v_o),
    .c_o      (c_o),
    .n_o      (n_o),
    .z_o      (z_o),
    .sout_r_o (sout_r_o),
    .sout_l_o (sout_l_o)
);

// File: tb/test_datapath_fu.sv
module test_datapath_fu;

    localparam int W   = 8;
    localparam int MSB = W - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a, b;
    logic [3:0]   fs;
    logic         fr, fl;
    logic [W-1:0] f;
    logic         v, c, n, z, sr, sl;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    datapath_fu #(.WIDTH(W)) i_datapath_fu (
        .a_i(a), .b_i(b), .fsel_i(fs), .fill_r_i(fr), .fill_l_i(fl),
        .f_o(f), .v_o(v), .c_o(c), .n_o(n), .z_o(z),
        .sout_r_o(sr), .sout_l_o(sl)
    );

    // Expected result from the requirement table (R1, R4..R7).
    function automatic logic [W-1:0] exp_f(input logic [W-1:0] ea, input logic [W-1:0] eb,
                                           input logic [3:0] code, input logic efr,
                                           input logic efl);
        case (code)
            4'b0000: return ea;
            4'b0001: return ea + 1'b1;
            4'b0010: return ea + eb;
            4'b0011: return ea + eb + 1'b1;
            4'b0100: return ea + ~eb;
            4'b0101: return ea - eb;
            4'b0110: return ea - 1'b1;
            4'b0111: return ea;
            4'b1000: return ea & eb;
            4'b1001: return ea | eb;
            4'b1010: return ea ^ eb;
            4'b1011: return ~ea;
            4'b1101: return {efr, eb[MSB:1]};
            4'b1110: return {eb[MSB-1:0], efl};
            default: return eb;
        endcase
    endfunction

    function automatic logic [W-1:0] exp_y(input logic [W-1:0] eb, input logic [3:0] code);
        case (code[2:1])
            2'b00:   return '0;
            2'b01:   return eb;
            2'b10:   return ~eb;
            default: return '1;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s fs=%b a=%h b=%h actual=%h expected=%h", tag, fs, a, b, act, expv);
        end
    endtask

    task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb_,
                         input logic [3:0] tfs, input logic tfr, input logic tfl);
        logic [W-1:0] y, ef;
        logic [W:0]   s;
        logic         ec, ev;
        @(negedge clk);
        a = ta; b = tb_; fs = tfs; fr = tfr; fl = tfl;
        #5;
        ef = exp_f(ta, tb_, tfs, tfr, tfl);
        y  = exp_y(tb_, tfs);
        s  = {1'b0, ta} + {1'b0, y} + {{W{1'b0}}, tfs[0]};
        ec = tfs[3] ? 1'b0 : s[W];
        ev = tfs[3] ? 1'b0 : ((ta[MSB] == y[MSB]) && (ef[MSB] != ta[MSB]));
        if (!tfs[3])                      chk("R1 result", f, ef);
        else if (!tfs[2])                 chk("R4 logic", f, ef);
        else if (tfs == 4'b1101)          chk("R6 shr", f, ef);
        else if (tfs == 4'b1110)          chk("R7 shl", f, ef);
        else                              chk("R5 pass", f, ef);
        chk(tfs[3] ? "R8 carry" : "R2 carry", {{(W-1){1'b0}}, c}, {{(W-1){1'b0}}, ec});
        chk(tfs[3] ? "R8 ovf" : "R3 ovf", {{(W-1){1'b0}}, v}, {{(W-1){1'b0}}, ev});
        chk("R9 neg", {{(W-1){1'b0}}, n}, {{(W-1){1'b0}}, ef[MSB]});
        chk("R9 zero", {{(W-1){1'b0}}, z}, {{(W-1){1'b0}}, (ef == '0)});
        chk("R10 serial", {{(W-2){1'b0}}, sr, sl}, {{(W-2){1'b0}}, tb_[0], tb_[MSB]});
    endtask

    initial begin
        a = '0; b = '0; fs = '0; fr = 1'b0; fl = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); #5;
        chk("R9 reset zero", {{(W-1){1'b0}}, z}, {{(W-1){1'b0}}, 1'b1});
        chk("R1 reset result", f, '0);
        // Directed corners: signed extremes and wrap points (R1, R2, R3)
        apply(8'h80, 8'h01, 4'b0101, 0, 0); // min - 1 overflows
        apply(8'h7F, 8'hFF, 4'b0101, 0, 0); // max - (-1) overflows
        apply(8'h80, 8'h00, 4'b0110, 0, 0); // decrement of min
        apply(8'h00, 8'h00, 4'b0110, 0, 0); // zero minus one
        apply(8'hFF, 8'h00, 4'b0001, 0, 0); // carry out, zero result
        apply(8'h7F, 8'h00, 4'b0001, 0, 0); // max + 1
        apply(8'h7F, 8'h01, 4'b0010, 0, 0);
        apply(8'h80, 8'h80, 4'b0010, 0, 0);
        apply(8'h5A, 8'h5A, 4'b0101, 0, 0); // equal operands subtract
        apply(8'h3C, 8'h11, 4'b0111, 0, 0);
        apply(8'h80, 8'h7F, 4'b0100, 0, 0);
        // Logic ops (R4) and shifts (R5..R7) with both fill values
        for (int k = 8; k < 16; k++) begin
            apply(8'hA5, 8'h81, 4'(k), 1'b1, 1'b1);
            apply(8'hA5, 8'h81, 4'(k), 1'b0, 1'b0);
            apply(8'hFF, 8'h00, 4'(k), 1'b0, 1'b0);
        end
        // Seeded random sweep over every code
        void'($urandom(32'd1357));
        for (int i = 0; i < 3000; i++)
            apply(8'($urandom), 8'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 100000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule